// File: doc/BRIEF.md
# Vector Micro-Operation Split Sequencer

This block sits after a row of six simple instruction decoders. Each cycle it receives a group of up to six decoded instructions. For each lane it gets a vector flag and the number of micro-operations (uops) the instruction expands into. Scalar instructions go straight to a six-slot output group. A vector instruction is first captured in a hold register. From the next cycle on, it is expanded into a stream of uops, at most six per cycle. The expansion can take several cycles. Scalar instructions that follow fill whatever slots the uops leave free.

Each uop carries the instruction tag, its index inside the instruction and a last-uop flag. Each uop also carries destination and source vector register numbers. These are the instruction's base register numbers plus the uop index. The downstream stage receives:

- a per-lane acceptance mask, which tells it which input lanes were consumed;
- a count of the slots taken by uops this cycle.

A rename-ready input stalls everything. A redirect input flushes the held instruction.

Top module: `vsplit_seq`

## Requirements
- R1: After reset no instruction is held. No output slot is valid, the acceptance mask is zero and complexNum is 0 until input arrives. A vector instruction can be accepted in the first cycle after reset.
- R2: Scalar lanes (inIsVec=0) that come before the first vector lane are accepted in the same cycle. Scalar lane i goes to output slot k+i, where k is the number of uops issued that cycle. Such a slot carries outIsVec=0, uop index 0 and outLast=1.
- R3: At most one vector lane is accepted per cycle. No lane after the first valid vector lane of a group is accepted in that cycle.
- R4: An accepted vector instruction emits no uop in the cycle it is accepted. Its first uop, with index 0, appears in slot 0 in the following cycle.
- R5: With n uops left to issue, min(n,6) uops are issued each cycle in slots 0 upward, in increasing index order. complexNum equals that number.
- R6: With n uops left and m scalars waiting before the first vector lane, all m are accepted when n+m ≤ 6. Otherwise only the first 6−n are accepted (none when n ≥ 6).
- R7: A vector lane is accepted only when nothing is held, or when the held instruction issues its last uops in that same cycle. In the second case the next instruction's uops start in the following cycle.
- R8: A uop with index x has outVd = (base vd + x) mod 32 and outVs = (base vs + x) mod 32. outLast=1 only on index (count − 1).
- R9: A vector instruction with a uop count of 1 still passes through the hold register. It yields one uop, with index 0 and outLast=1, one cycle after acceptance.
- R10: While renameReady is 0, no slot is valid, no lane is accepted, complexNum is 0, and the held instruction and its progress are kept.
- R11: While redirect is 1, no slot is valid and no lane is accepted. The held instruction is dropped, so no uop of it appears afterwards.
- R12: Lanes are accepted strictly in order. A lane that is not valid stops acceptance of all higher lanes in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 6 | Lane holds an instruction |
| inIsVec | input | 6 | Lane is a vector instruction |
| inUopNum | input | 30 | Per-lane uop count, 5 bits per lane (1..16) |
| inId | input | 48 | Per-lane instruction tag, 8 bits per lane |
| inVd | input | 30 | Per-lane destination register, 5 bits per lane |
| inVs | input | 30 | Per-lane source register, 5 bits per lane |
| renameReady | input | 1 | Downstream can take a group this cycle |
| redirect | input | 1 | Flush held instruction and outputs |
| outValid | output | 6 | Slot valid |
| outIsVec | output | 6 | Slot holds a vector uop |
| outId | output | 48 | Slot tag, 8 bits per slot |
| outVd | output | 30 | Slot destination register, 5 bits per slot |
| outVs | output | 30 | Slot source register, 5 bits per slot |
| outUopIdx | output | 30 | Slot uop index, 5 bits per slot |
| outLast | output | 6 | Slot is the last uop of its instruction |
| accept | output | 6 | Lanes consumed this cycle |
| complexNum | output | 3 | Slots filled by split uops this cycle |

## Verification
The hardest situation to reach is the hand-over cycle. In that cycle a held instruction issues its final few uops while a new vector instruction and several scalars share the same group. It decides at once how many scalars fit next to the tail uops and whether the next vector is captured. The stimulus reaches it on purpose with long uop counts (13 and 14) that leave tails of 1 and 2. It then pairs them with mixed groups, stalls and redirects in a long pseudo-random sweep. A bench-side model computes the expected slots arithmetically for every cycle.

// File: rtl/vsplit_pkg.sv
package vsplit_pkg;
  parameter int LANES    = 6;
  parameter int MAX_UOPS = 16;
  parameter int ID_W     = 8;
  parameter int REG_W    = 5;

  localparam int UOP_W  = $clog2(MAX_UOPS + 1);
  localparam int CNT_W  = $clog2(LANES + 1);
  localparam int LANE_W = $clog2(LANES);

  typedef struct packed {
    logic              loadHold;
    logic [LANE_W-1:0] loadLane;
    logic [CNT_W-1:0]  issueCnt;
    logic [UOP_W-1:0]  baseIdx;
    logic              finishing;
    logic [LANES-1:0]  scalarTake;
  } seqStrobe_t;
endpackage

// File: rtl/vsplit_ctrl.sv
module vsplit_ctrl
  import vsplit_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [LANES-1:0]       inValid,
  input  logic [LANES-1:0]       inIsVec,
  input  logic [LANES*UOP_W-1:0] inUopNum,
  input  logic                   renameReady,
  input  logic                   redirect,
  output logic [LANES-1:0]       accept,
  output seqStrobe_t             strobe
);
  logic             holdValid;
  logic [UOP_W-1:0] holdTotal;
  logic [UOP_W-1:0] nextIdx;
  logic [UOP_W-1:0] remain;
  logic             go;
  logic             finishing;
  logic             splitReady;
  logic [CNT_W-1:0] issueCnt;
  logic             vecTake;
  logic [LANE_W-1:0] vecLane;
  logic [LANES-1:0] scalarTake;
  logic [UOP_W-1:0] loadTotal;

  assign go         = renameReady && !redirect;
  assign remain     = holdValid ? (holdTotal - nextIdx) : '0;
  assign finishing  = holdValid && go && (remain <= UOP_W'(LANES));
  assign splitReady = !holdValid || finishing;

  always_comb begin
    if (!go || !holdValid)               issueCnt = '0;
    else if (remain > UOP_W'(LANES))     issueCnt = CNT_W'(LANES);
    else                                 issueCnt = CNT_W'(remain);
  end

  // In-order lane walk: scalars fill free slots, first vector lane ends the walk
  always_comb begin
    logic blocked;
    blocked    = !go;
    vecTake    = 1'b0;
    vecLane    = '0;
    scalarTake = '0;
    accept     = '0;
    for (int i = 0; i < LANES; i++) begin
      if (!blocked) begin
        if (!inValid[i]) begin
          blocked = 1'b1;
        end else if (inIsVec[i]) begin
          if (splitReady) begin
            vecTake   = 1'b1;
            vecLane   = LANE_W'(i);
            accept[i] = 1'b1;
          end
          blocked = 1'b1;
        end else if (i + int'(issueCnt) < LANES) begin
          scalarTake[i] = 1'b1;
          accept[i]     = 1'b1;
        end else begin
          blocked = 1'b1;
        end
      end
    end
  end

  assign loadTotal = inUopNum[vecLane*UOP_W +: UOP_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      holdTotal <= '0;
      nextIdx   <= '0;
    end else if (redirect) begin
      holdValid <= 1'b0;
      nextIdx   <= '0;
    end else begin
      if (finishing) begin
        holdValid <= 1'b0;
        nextIdx   <= '0;
      end else if (holdValid && go) begin
        nextIdx <= nextIdx + UOP_W'(issueCnt);
      end
      if (vecTake) begin
        holdValid <= 1'b1;
        holdTotal <= loadTotal;
        nextIdx   <= '0;
      end
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.loadHold   = vecTake;
    strobe.loadLane   = vecLane;
    strobe.issueCnt   = issueCnt;
    strobe.baseIdx    = nextIdx;
    strobe.finishing  = finishing;
    strobe.scalarTake = scalarTake;
  end

  assert_remain_live_R5: assert property (@(posedge clk) disable iff (!rstN)
    holdValid |-> (nextIdx < holdTotal));
  assert_slot_budget_R6: assert property (@(posedge clk) disable iff (!rstN)
    (int'(issueCnt) + $countones(scalarTake)) <= LANES);
  assert_one_vector_R3: assert property (@(posedge clk) disable iff (!rstN)
    $countones(accept & inIsVec) <= 1);
  assert_load_delay_R4: assert property (@(posedge clk) disable iff (!rstN)
    vecTake |=> (holdValid && nextIdx == '0));
  assert_handover_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((accept & inIsVec) != '0 && holdValid) |-> (remain <= UOP_W'(LANES) && issueCnt == CNT_W'(remain)));
  assert_stall_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !renameReady |-> (accept == '0 && issueCnt == '0));
  assert_stall_keep_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!renameReady && !redirect) |=> ($stable(nextIdx) && $stable(holdValid)));
  assert_flush_R11: assert property (@(posedge clk) disable iff (!rstN)
    redirect |=> !holdValid);
endmodule

// File: rtl/vsplit_data.sv
module vsplit_data
  import vsplit_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  seqStrobe_t             strobe,
  input  logic [LANES*ID_W-1:0]  inId,
  input  logic [LANES*REG_W-1:0] inVd,
  input  logic [LANES*REG_W-1:0] inVs,
  output logic [LANES-1:0]       outValid,
  output logic [LANES-1:0]       outIsVec,
  output logic [LANES*ID_W-1:0]  outId,
  output logic [LANES*REG_W-1:0] outVd,
  output logic [LANES*REG_W-1:0] outVs,
  output logic [LANES*UOP_W-1:0] outUopIdx,
  output logic [LANES-1:0]       outLast
);
  logic [ID_W-1:0]  holdId;
  logic [REG_W-1:0] holdVd;
  logic [REG_W-1:0] holdVs;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdId <= '0;
      holdVd <= '0;
      holdVs <= '0;
    end else if (strobe.loadHold) begin
      holdId <= inId[strobe.loadLane*ID_W +: ID_W];
      holdVd <= inVd[strobe.loadLane*REG_W +: REG_W];
      holdVs <= inVs[strobe.loadLane*REG_W +: REG_W];
    end
  end

  for (genvar j = 0; j < LANES; j++) begin : g_slot
    logic             sValid, sVec, sLast;
    logic [ID_W-1:0]  sId;
    logic [REG_W-1:0] sVd, sVs;
    logic [UOP_W-1:0] sIdx;

    always_comb begin
      sValid = 1'b0;
      sVec   = 1'b0;
      sLast  = 1'b0;
      sId    = '0;
      sVd    = '0;
      sVs    = '0;
      sIdx   = '0;
      if (CNT_W'(j) < strobe.issueCnt) begin
        sValid = 1'b1;
        sVec   = 1'b1;
        sIdx   = strobe.baseIdx + UOP_W'(j);
        sId    = holdId;
        sVd    = holdVd + REG_W'(sIdx);
        sVs    = holdVs + REG_W'(sIdx);
        sLast  = strobe.finishing && (CNT_W'(j + 1) == strobe.issueCnt);
      end else begin
        for (int l = 0; l < LANES; l++) begin
          if (strobe.scalarTake[l] && (l + int'(strobe.issueCnt) == j)) begin
            sValid = 1'b1;
            sLast  = 1'b1;
            sId    = inId[l*ID_W +: ID_W];
            sVd    = inVd[l*REG_W +: REG_W];
            sVs    = inVs[l*REG_W +: REG_W];
          end
        end
      end
    end

    assign outValid[j]                    = sValid;
    assign outIsVec[j]                    = sVec;
    assign outLast[j]                     = sLast;
    assign outId[j*ID_W +: ID_W]          = sId;
    assign outVd[j*REG_W +: REG_W]        = sVd;
    assign outVs[j*REG_W +: REG_W]        = sVs;
    assign outUopIdx[j*UOP_W +: UOP_W]    = sIdx;
  end

  assert_dense_slots_R12: assert property (@(posedge clk) disable iff (!rstN)
    ((outValid + 1'b1) & outValid) == '0);
  assert_uops_first_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((outIsVec + 1'b1) & outIsVec) == '0);
endmodule

// File: rtl/vsplit_seq.sv
module vsplit_seq
  import vsplit_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [LANES-1:0]       inValid,
  input  logic [LANES-1:0]       inIsVec,
  input  logic [LANES*UOP_W-1:0] inUopNum,
  input  logic [LANES*ID_W-1:0]  inId,
  input  logic [LANES*REG_W-1:0] inVd,
  input  logic [LANES*REG_W-1:0] inVs,
  input  logic                   renameReady,
  input  logic                   redirect,
  output logic [LANES-1:0]       outValid,
  output logic [LANES-1:0]       outIsVec,
  output logic [LANES*ID_W-1:0]  outId,
  output logic [LANES*REG_W-1:0] outVd,
  output logic [LANES*REG_W-1:0] outVs,
  output logic [LANES*UOP_W-1:0] outUopIdx,
  output logic [LANES-1:0]       outLast,
  output logic [LANES-1:0]       accept,
  output logic [CNT_W-1:0]       complexNum
);
  seqStrobe_t strobe;

  vsplit_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inIsVec(inIsVec),
    .inUopNum(inUopNum), .renameReady(renameReady), .redirect(redirect),
    .accept(accept), .strobe(strobe)
  );

  vsplit_data u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inId(inId), .inVd(inVd), .inVs(inVs),
    .outValid(outValid), .outIsVec(outIsVec), .outId(outId), .outVd(outVd),
    .outVs(outVs), .outUopIdx(outUopIdx), .outLast(outLast)
  );

  assign complexNum = strobe.issueCnt;
endmodule

// File: tb/vsplit_seq_tb.sv
module vsplit_seq_tb;
  import vsplit_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic                   lv [LANES];
  logic                   lvec [LANES];
  int                     lnum [LANES];
  int                     lid [LANES];
  int                     lvd [LANES];
  int                     lvs [LANES];
  logic                   rr = 1'b1;
  logic                   rd = 1'b0;

  logic [LANES-1:0]       inValid, inIsVec;
  logic [LANES*UOP_W-1:0] inUopNum;
  logic [LANES*ID_W-1:0]  inId;
  logic [LANES*REG_W-1:0] inVd, inVs;
  logic [LANES-1:0]       outValid, outIsVec, outLast, accept;
  logic [LANES*ID_W-1:0]  outId;
  logic [LANES*REG_W-1:0] outVd, outVs;
  logic [LANES*UOP_W-1:0] outUopIdx;
  logic [CNT_W-1:0]       complexNum;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      inValid[i] = lv[i];
      inIsVec[i] = lvec[i];
      inUopNum[i*UOP_W +: UOP_W] = UOP_W'(lnum[i]);
      inId[i*ID_W +: ID_W]       = ID_W'(lid[i]);
      inVd[i*REG_W +: REG_W]     = REG_W'(lvd[i]);
      inVs[i*REG_W +: REG_W]     = REG_W'(lvs[i]);
    end
  end

  vsplit_seq u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inIsVec(inIsVec), .inUopNum(inUopNum),
    .inId(inId), .inVd(inVd), .inVs(inVs), .renameReady(rr), .redirect(rd),
    .outValid(outValid), .outIsVec(outIsVec), .outId(outId), .outVd(outVd), .outVs(outVs),
    .outUopIdx(outUopIdx), .outLast(outLast), .accept(accept), .complexNum(complexNum)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // bench model state
  bit mHold = 0;
  int mTotal = 0, mNext = 0, mId = 0, mVd = 0, mVs = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  function automatic int rnd(int m);
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return int'(lfsr[15:0]) % m;
  endfunction

  task automatic clearLanes();
    for (int i = 0; i < LANES; i++) begin
      lv[i] = 0; lvec[i] = 0; lnum[i] = 1; lid[i] = 0; lvd[i] = 0; lvs[i] = 0;
    end
  endtask

  task automatic setLane(int i, bit vec, int num, int id, int vd, int vs);
    lv[i] = 1; lvec[i] = vec; lnum[i] = num; lid[i] = id; lvd[i] = vd; lvs[i] = vs;
  endtask

  task automatic stepCycle(string tag);
    int n, k, vecL, idx, l;
    bit go, fin, ready, blk, bad;
    logic [LANES-1:0] eAcc, eVal, eVec, eLast;
    int eId [LANES];
    int eVd [LANES];
    int eVs [LANES];
    int eIdx [LANES];
    @(negedge clk);
    #2;
    n = mHold ? mTotal - mNext : 0;
    go = rr && !rd;
    k = (go && mHold) ? ((n > LANES) ? LANES : n) : 0;
    fin = mHold && go && (n <= LANES);
    ready = !mHold || fin;
    eAcc = '0; blk = !go; vecL = -1;
    for (int i = 0; i < LANES; i++) begin
      if (blk || !lv[i]) blk = 1;
      else if (lvec[i]) begin
        if (ready) begin eAcc[i] = 1; vecL = i; end
        blk = 1;
      end else if (i + k < LANES) eAcc[i] = 1;
      else blk = 1;
    end
    eVal = '0; eVec = '0; eLast = '0;
    for (int j = 0; j < LANES; j++) begin
      eId[j] = 0; eVd[j] = 0; eVs[j] = 0; eIdx[j] = 0;
      if (j < k) begin
        idx = mNext + j;
        eVal[j] = 1; eVec[j] = 1; eIdx[j] = idx; eId[j] = mId;
        eVd[j] = (mVd + idx) % 32; eVs[j] = (mVs + idx) % 32;
        eLast[j] = (idx == mTotal - 1);
      end else begin
        l = j - k;
        if (eAcc[l] && !lvec[l]) begin
          eVal[j] = 1; eLast[j] = 1; eId[j] = lid[l]; eVd[j] = lvd[l]; eVs[j] = lvs[l];
        end
      end
    end
    bad = (outValid !== eVal) || (accept !== eAcc) || (complexNum !== CNT_W'(k));
    for (int j = 0; j < LANES; j++)
      if (eVal[j])
        bad |= (outIsVec[j] !== eVec[j]) || (outLast[j] !== eLast[j]) ||
               (outId[j*ID_W +: ID_W] !== ID_W'(eId[j])) ||
               (outVd[j*REG_W +: REG_W] !== REG_W'(eVd[j])) ||
               (outVs[j*REG_W +: REG_W] !== REG_W'(eVs[j])) ||
               (outUopIdx[j*UOP_W +: UOP_W] !== UOP_W'(eIdx[j]));
    checks++;
    if (bad) begin
      fails++;
      $display("FAIL %s: valid=%h acc=%h cnum=%0d isvec=%h last=%h | expected valid=%h acc=%h cnum=%0d isvec=%h last=%h",
               tag, outValid, accept, complexNum, outIsVec, outLast, eVal, eAcc, k, eVec, eLast);
    end
    if (rd) mHold = 0;
    else begin
      if (fin) mHold = 0;
      else if (mHold && go) mNext += k;
      if (vecL >= 0) begin
        mHold = 1; mNext = 0; mTotal = lnum[vecL];
        mId = lid[vecL]; mVd = lvd[vecL]; mVs = lvs[vecL];
      end
    end
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    clearLanes();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: idle after reset
    stepCycle("R1 idle");
    // R2: six scalars pass straight through
    for (int i = 0; i < LANES; i++) setLane(i, 0, 1, 16 + i, i, 10 + i);
    stepCycle("R2 all scalar");
    // R3: scalar, vector, scalar; R1 vector taken right after reset state
    clearLanes();
    setLane(0, 0, 1, 1, 3, 4); setLane(1, 1, 3, 2, 8, 12); setLane(2, 0, 1, 3, 5, 5);
    stepCycle("R3 vector blocks later lanes");
    // R4: its uops appear next cycle; the leftover scalar joins behind them
    clearLanes(); setLane(0, 0, 1, 3, 5, 5);
    stepCycle("R4 uops after one cycle");
    // R9: single-uop vector
    clearLanes(); setLane(0, 1, 1, 40, 7, 9);
    stepCycle("R9 single uop accept");
    clearLanes();
    stepCycle("R9 single uop issue");
    // R5/R6: 14-uop vector with scalars waiting
    setLane(0, 1, 14, 50, 30, 28);
    stepCycle("R5 accept long vector");
    clearLanes();
    for (int i = 0; i < 4; i++) setLane(i, 0, 1, 60 + i, i, i);
    stepCycle("R6 full uop cycle blocks scalars");
    // R10: stall keeps progress
    rr = 0;
    stepCycle("R10 stall");
    rr = 1;
    stepCycle("R8 second batch wraps registers");
    // R7: tail of 2 uops, next vector accepted in the same cycle, scalar before it
    clearLanes();
    setLane(0, 0, 1, 70, 1, 1); setLane(1, 1, 13, 71, 2, 6); setLane(2, 0, 1, 72, 0, 0);
    stepCycle("R7 handover cycle");
    clearLanes();
    stepCycle("R7 next vector starts");
    // R11: redirect drops the held instruction
    rd = 1;
    stepCycle("R11 redirect");
    rd = 0;
    stepCycle("R11 nothing after redirect");
    // R12: gap stops acceptance
    for (int i = 0; i < LANES; i++) setLane(i, 0, 1, 80 + i, i, i);
    lv[2] = 0;
    stepCycle("R12 invalid lane gap");
    clearLanes();

    // mixed sweep
    for (int c = 0; c < 4000; c++) begin
      int cnt;
      clearLanes();
      cnt = rnd(LANES + 1);
      for (int i = 0; i < cnt; i++)
        setLane(i, rnd(4) == 0, 1 + rnd(MAX_UOPS), rnd(256), rnd(32), rnd(32));
      if (rnd(16) == 0 && cnt > 0) lv[rnd(cnt)] = 0;
      rr = (rnd(8) != 0);
      rd = (rnd(40) == 0);
      stepCycle("R6 sweep");
    end
    rr = 1; rd = 0; clearLanes();
    stepCycle("R5 sweep drain");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule